// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Slave

This block is a half-duplex synchronous serial slave. A remote master supplies the serial clock, and the block moves words over a single data line. The direction is chosen by a static mode input. Both shift registers are clocked only by the incoming serial clock, so words keep moving while the local host clock is stopped. When a word is finished, a wake request can be raised that brings a sleeping host back.

On the host side, the block offers the following:

- a transmit holding register, which makes transmit double-buffered;
- a receive buffer;
- receive-complete, transmit-ready and overrun flags;
- per-source interrupt enables and a peripheral-level enable.

Events cross from the serial clock domain to the host clock domain through toggle handshakes with multi-flop synchronisers. The data line is presented as a separate input, output and output-enable, so the pad can tristate it.

Top module: `xclk_slave`

## Requirements
- R1: After reset, `rx_full_o`, `ovr_o`, `ser_dat_oe_o` and `rx_data_o` are 0 and `tx_ready_o` is 1.
- R2: With `dir_tx_i` = 0, `ser_dat_i` is sampled on every rising edge of `ser_clk_i`, bit 0 first. Word boundaries are counted from reset. After the last bit of a word, and within a few host cycles, `rx_data_o` holds the word and `rx_full_o` is 1.
- R3: A one-cycle `rd_rx_i` pulse while `rx_full_o` is 1 clears `rx_full_o`.
- R4: If a word completes while `rx_full_o` is 1, `ovr_o` sets and the word is dropped. While `ovr_o` stays 1, every later word is also dropped. `rx_data_o` is unchanged throughout. A one-cycle `ovr_clr_i` pulse clears `ovr_o`.
- R5: With `dir_tx_i` = 1, a byte held for transmission is loaded into the shift register on a falling edge of `ser_clk_i`, and this edge may be as late as the third falling edge after the write. The byte is then driven on `ser_dat_o`, bit 0 first, one bit per falling edge. `ser_dat_oe_o` is 1 only while the shift register holds a word.
- R6: A `wr_tx_i` pulse while `tx_ready_o` is 1 stores `wr_data_i` and clears `tx_ready_o`. A write while `tx_ready_o` is 0 is ignored. `tx_ready_o` returns to 1 once the held byte has moved into the shift register.
- R7: If a byte is waiting when the last bit of a word has been driven, the next falling edge loads it. The output enable stays high, and no idle clock separates the two words.
- R8: With the host clock running, `wake_o` = `pie_i` & ((`rx_ie_i` & `rx_full_o`) | (`tx_ie_i` & `tx_ready_o`)).
- R9: While the host clock is stopped, a completed received word, or a held byte moving into the transmit shift register, raises `wake_o` if its enables are set. The host flags update only after the host clock resumes.
- R10: With `dir_tx_i` = 1, clocks arriving with nothing to send leave `ser_dat_oe_o` at 0 and deliver no received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; may be stopped during sleep |
| rst_n | input | 1 | Active-low reset, synchronous to both clocks |
| ser_clk_i | input | 1 | Serial clock from the remote master |
| ser_dat_i | input | 1 | Data line input (receive) |
| ser_dat_o | output | 1 | Data line output value (transmit) |
| ser_dat_oe_o | output | 1 | Data line output enable; 0 = tristate |
| dir_tx_i | input | 1 | Direction: 1 transmit, 0 receive |
| wr_tx_i | input | 1 | Write strobe for the transmit holding register |
| wr_data_i | input | WORD_W | Byte to transmit |
| rd_rx_i | input | 1 | Read strobe for the receive buffer |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rx_ie_i | input | 1 | Receive-complete wake enable |
| tx_ie_i | input | 1 | Transmit-ready wake enable |
| pie_i | input | 1 | Peripheral-level wake enable |
| rx_data_o | output | WORD_W | Receive buffer |
| rx_full_o | output | 1 | Receive-complete flag |
| tx_ready_o | output | 1 | Transmit holding register empty |
| ovr_o | output | 1 | Receive overrun flag |
| wake_o | output | 1 | Wake / interrupt request to the host |

## Verification
The bench builds the block with WORD_W = 8 and SYNC_STAGES = 2. With 8-bit words, every one of the 256 codes is swept through both the receive and the transmit path. With two synchroniser stages, the handshake latency stays at a few host cycles, so the exact bit positions can be checked during back-to-back transmit and flag turnaround. All eight enable combinations are applied in each of four flag states and compared with the wake formula. The host clock is also stopped outright, to show that words still complete and wake asserts without it.

// File: rtl/xclk_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the externally clocked serial slave.
// Assumes: word widths of at least 2 bits.
package xclk_pkg;
    // Width of a counter that walks the bit positions of one word.
    function automatic int bit_cnt_w(input int word_w);
        return (word_w < 2) ? 1 : $clog2(word_w);
    endfunction
endpackage

// File: rtl/xclk_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a single level or toggle signal.
// Assumes: STAGES >= 2; NEG selects the falling edge of clk as the capture edge.
module xclk_sync #(
    parameter int STAGES = 2,
    parameter bit NEG    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (NEG) begin : g_neg
            // Capture chain on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end else begin : g_pos
            // Capture chain on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xclk_rx_shift.sv
`timescale 1ns/1ps
// Receive shifter, clocked only by the remote serial clock.
// Samples the data line on rising edges, LSB first. On each completed word it
// latches the word and flips a toggle for the host side.
// Assumes: word boundaries count from reset; word_o stays stable for a whole
// word time, which is longer than the host synchroniser latency.
module xclk_rx_shift #(
    parameter int WORD_W = 8
) (
    input  logic              ser_clk_i,
    input  logic              rst_n,
    input  logic              dir_tx_i,
    input  logic              dat_i,
    output logic [WORD_W-1:0] word_o,
    output logic              tgl_o
);
    import xclk_pkg::*;
    localparam int CNT_W = bit_cnt_w(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    // Shift in one bit per rising edge; hand over a finished word.
    always_ff @(posedge ser_clk_i) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            word_o <= '0;
            tgl_o  <= 1'b0;
        end else if (dir_tx_i) begin
            cnt <= '0;
        end else begin
            sh <= {dat_i, sh[WORD_W-1:1]};
            if (cnt == LAST) begin
                word_o <= {dat_i, sh[WORD_W-1:1]};
                tgl_o  <= ~tgl_o;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_RX_WORD_EVENT: assert property (@(posedge ser_clk_i) disable iff (!rst_n) (!dir_tx_i && cnt == LAST) |=> (tgl_o != $past(tgl_o))); // R2
    AST_RX_WORD_HOLD: assert property (@(posedge ser_clk_i) disable iff (!rst_n) (dir_tx_i || cnt != LAST) |=> $stable(word_o)); // R2
    AST_RX_IDLE_IN_TX: assert property (@(posedge ser_clk_i) disable iff (!rst_n) dir_tx_i |=> (cnt == '0)); // R10
endmodule

// File: rtl/xclk_tx_shift.sv
`timescale 1ns/1ps
// Transmit shifter, clocked only by the remote serial clock.
// Drives the data line on falling edges, LSB first. It loads the host holding
// register whenever the synchronised request toggle differs from its own
// acknowledge toggle, and the shift register is empty or finishing a word.
// Assumes: hold_i stays stable while a request is pending (the host enforces this).
module xclk_tx_shift #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              ser_clk_i,
    input  logic              rst_n,
    input  logic              dir_tx_i,
    input  logic              req_tgl_i,
    input  logic [WORD_W-1:0] hold_i,
    output logic              dat_o,
    output logic              oe_o,
    output logic              ack_tgl_o
);
    import xclk_pkg::*;
    localparam int CNT_W = bit_cnt_w(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              busy;
    logic              req_s;
    logic              pending;

    xclk_sync #(.STAGES(SYNC_STAGES), .NEG(1'b1)) u_req_sync (
        .clk   (ser_clk_i),
        .rst_n (rst_n),
        .d_i   (req_tgl_i),
        .q_o   (req_s)
    );

    assign pending = (req_s != ack_tgl_o);

    // Load, shift or go idle on each falling edge.
    always_ff @(negedge ser_clk_i) begin
        if (!rst_n) begin
            sh        <= '0;
            cnt       <= '0;
            busy      <= 1'b0;
            ack_tgl_o <= 1'b0;
        end else if (!dir_tx_i) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy || cnt == LAST) begin
            cnt <= '0;
            if (pending) begin
                sh        <= hold_i;
                busy      <= 1'b1;
                ack_tgl_o <= ~ack_tgl_o;
            end else begin
                busy <= 1'b0;
            end
        end else begin
            sh  <= sh >> 1;
            cnt <= cnt + 1'b1;
        end
    end

    assign dat_o = busy & sh[0];
    assign oe_o  = busy & dir_tx_i;

    AST_TX_SHIFT_LSB: assert property (@(negedge ser_clk_i) disable iff (!rst_n) (dir_tx_i && busy && cnt != LAST) |=> (sh == ($past(sh) >> 1))); // R5
    AST_TX_ACK_ON_LOAD: assert property (@(negedge ser_clk_i) disable iff (!rst_n) (ack_tgl_o != $past(ack_tgl_o)) |-> (busy && cnt == '0)); // R6
    AST_TX_BACK_TO_BACK: assert property (@(negedge ser_clk_i) disable iff (!rst_n) (dir_tx_i && busy && cnt == LAST && pending) |=> (busy && cnt == '0)); // R7
endmodule

// File: rtl/xclk_host_regs.sv
`timescale 1ns/1ps
// Host-side register logic: receive buffer, overrun, transmit holding register,
// ready flag and wake request. Serial-domain toggles are synchronised here.
// Wake also looks at the raw serial-domain toggles, so it can rise with clk stopped.
// Assumes: the host clock is faster than the serial clock.
module xclk_host_regs #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_tx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_rx_i,
    input  logic              ovr_clr_i,
    input  logic              rx_ie_i,
    input  logic              tx_ie_i,
    input  logic              pie_i,
    input  logic              rx_tgl_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              ack_tgl_i,
    output logic              req_tgl_o,
    output logic [WORD_W-1:0] tx_hold_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              tx_ready_o,
    output logic              ovr_o,
    output logic              wake_o
);
    logic rx_tgl_s;
    logic rx_seen;
    logic rx_evt;
    logic ack_s;

    xclk_sync #(.STAGES(SYNC_STAGES), .NEG(1'b0)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_tgl_i),
        .q_o   (rx_tgl_s)
    );

    xclk_sync #(.STAGES(SYNC_STAGES), .NEG(1'b0)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_tgl_i),
        .q_o   (ack_s)
    );

    assign rx_evt = rx_tgl_s ^ rx_seen;

    // Remember the last receive toggle already handled.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_seen <= 1'b0;
        else        rx_seen <= rx_tgl_s;
    end

    // Receive buffer, receive-complete and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_o <= '0;
            rx_full_o <= 1'b0;
            ovr_o     <= 1'b0;
        end else begin
            if (rd_rx_i)   rx_full_o <= 1'b0;
            if (ovr_clr_i) ovr_o     <= 1'b0;
            if (rx_evt) begin
                if (rx_full_o || ovr_o) begin
                    ovr_o <= 1'b1;
                end else begin
                    rx_data_o <= rx_word_i;
                    rx_full_o <= 1'b1;
                end
            end
        end
    end

    assign tx_ready_o = (req_tgl_o == ack_s);

    // Transmit holding register and request toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold_o <= '0;
            req_tgl_o <= 1'b0;
        end else if (wr_tx_i && tx_ready_o) begin
            tx_hold_o <= wr_data_i;
            req_tgl_o <= ~req_tgl_o;
        end
    end

    // Wake from registered flags or from serial-side events not yet seen by the host.
    assign wake_o = pie_i & ((rx_ie_i & (rx_full_o | (rx_tgl_i ^ rx_seen)))
                           | (tx_ie_i & (req_tgl_o == ack_tgl_i)));

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_rx_i && rx_full_o) |=> !rx_full_o); // R3
    AST_OVR_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n) (ovr_o && !ovr_clr_i) |=> $stable(rx_data_o)); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovr_o && !ovr_clr_i) |=> ovr_o); // R4
    AST_WR_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n) (wr_tx_i && tx_ready_o) |=> !tx_ready_o); // R6
    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_tx_i && !tx_ready_o) |=> $stable(tx_hold_o)); // R6
    AST_WAKE_RX: assert property (@(posedge clk) disable iff (!rst_n) (pie_i && rx_ie_i && rx_full_o) |-> wake_o); // R8
endmodule

// File: rtl/xclk_slave.sv
`timescale 1ns/1ps
// Top of the externally clocked synchronous serial slave.
// Shifting runs entirely on ser_clk_i; flags live in the host clock domain and
// are fed by toggle handshakes. wake_o can rise while clk is stopped.
// Assumes: rst_n is held over at least two edges of both clocks; dir_tx_i
// changes only while no word is in flight.
module xclk_slave #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    output logic              ser_dat_o,
    output logic              ser_dat_oe_o,
    input  logic              dir_tx_i,
    input  logic              wr_tx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_rx_i,
    input  logic              ovr_clr_i,
    input  logic              rx_ie_i,
    input  logic              tx_ie_i,
    input  logic              pie_i,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              tx_ready_o,
    output logic              ovr_o,
    output logic              wake_o
);
    logic [WORD_W-1:0] rx_word;
    logic              rx_tgl;
    logic              ack_tgl;
    logic              req_tgl;
    logic [WORD_W-1:0] tx_hold;

    xclk_rx_shift #(.WORD_W(WORD_W)) u_rx (
        .ser_clk_i (ser_clk_i),
        .rst_n     (rst_n),
        .dir_tx_i  (dir_tx_i),
        .dat_i     (ser_dat_i),
        .word_o    (rx_word),
        .tgl_o     (rx_tgl)
    );

    xclk_tx_shift #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
        .ser_clk_i (ser_clk_i),
        .rst_n     (rst_n),
        .dir_tx_i  (dir_tx_i),
        .req_tgl_i (req_tgl),
        .hold_i    (tx_hold),
        .dat_o     (ser_dat_o),
        .oe_o      (ser_dat_oe_o),
        .ack_tgl_o (ack_tgl)
    );

    xclk_host_regs #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_tx_i    (wr_tx_i),
        .wr_data_i  (wr_data_i),
        .rd_rx_i    (rd_rx_i),
        .ovr_clr_i  (ovr_clr_i),
        .rx_ie_i    (rx_ie_i),
        .tx_ie_i    (tx_ie_i),
        .pie_i      (pie_i),
        .rx_tgl_i   (rx_tgl),
        .rx_word_i  (rx_word),
        .ack_tgl_i  (ack_tgl),
        .req_tgl_o  (req_tgl),
        .tx_hold_o  (tx_hold),
        .rx_data_o  (rx_data_o),
        .rx_full_o  (rx_full_o),
        .tx_ready_o (tx_ready_o),
        .ovr_o      (ovr_o),
        .wake_o     (wake_o)
    );
endmodule

// File: tb/xclk_slave_bench.sv
`timescale 1ns/1ps
// Self-checking bench: 100 MHz host clock; the serial master is modelled with
// 40 ns serial periods driven from tasks.
module xclk_slave_bench;
    localparam int W    = 8;
    localparam int HALF = 20;

    logic         clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
    logic         ser_clk = 1'b1, ser_dat_i = 1'b0, dir_tx = 1'b0;
    logic         wr = 1'b0, rd = 1'b0, ovr_clr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         rie = 1'b0, tie = 1'b0, pie = 1'b0;
    logic         dat_o, oe, rx_full, tx_ready, ovr, wake;
    logic [W-1:0] rx_data;

    int          checks = 0, errors = 0;
    logic [31:0] cap;
    int          capn, gaps;

    xclk_slave #(.WORD_W(W), .SYNC_STAGES(2)) u_xclk_slave (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat_i),
        .ser_dat_o(dat_o), .ser_dat_oe_o(oe), .dir_tx_i(dir_tx),
        .wr_tx_i(wr), .wr_data_i(wdata), .rd_rx_i(rd), .ovr_clr_i(ovr_clr),
        .rx_ie_i(rie), .tx_ie_i(tie), .pie_i(pie),
        .rx_data_o(rx_data), .rx_full_o(rx_full), .tx_ready_o(tx_ready),
        .ovr_o(ovr), .wake_o(wake)
    );

    always #5 if (clk_en) clk = ~clk; else clk = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) begin
            ser_clk = 1'b0; ser_dat_i = w[i]; #HALF;
            ser_clk = 1'b1; #HALF;
        end
    endtask

    task automatic cap_clear();
        cap = '0; capn = 0; gaps = 0;
    endtask

    task automatic tx_run(input int n);
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0; #HALF;
            ser_clk = 1'b1; #1;
            if (oe) begin
                if (capn < 32) cap[capn] = dat_o;
                capn++;
            end else if (capn > 0 && capn < 16) begin
                gaps++;
            end
            #(HALF-1);
        end
    endtask

    task automatic host_write(input logic [W-1:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic sweep_wake(input logic rf, input logic tr);
        for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            pie = e[2]; rie = e[1]; tie = e[0];
            #1;
            check("R8 wake", {31'b0, wake}, {31'b0, e[2] & ((e[1] & rf) | (e[0] & tr))});
        end
        @(negedge clk); pie = 0; rie = 0; tie = 0;
    endtask

    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL WATCHDOG timeout actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cap_clear();
        tx_run(4);
        hclk(2);
        rst_n = 1'b1;
        hclk(2);
        // R1 reset state
        check("R1 rx_full", {31'b0, rx_full}, 0);
        check("R1 tx_ready", {31'b0, tx_ready}, 1);
        check("R1 ovr", {31'b0, ovr}, 0);
        check("R1 oe", {31'b0, oe}, 0);
        check("R1 rx_data", {24'b0, rx_data}, 0);
        check("R1 wake", {31'b0, wake}, 0);

        // R2/R3 receive sweep over every code, also R10 oe low in receive mode
        for (int v = 0; v < 256; v++) begin
            send_word(v[7:0]);
            hclk(8);
            check("R2 rx_full", {31'b0, rx_full}, 1);
            check("R2 rx_data", {24'b0, rx_data}, v);
            check("R10 oe rx mode", {31'b0, oe}, 0);
            host_read();
            check("R3 read clears", {31'b0, rx_full}, 0);
        end

        // R4 overrun
        send_word(8'h3C); hclk(8);
        send_word(8'hA5); hclk(8);
        check("R4 ovr set", {31'b0, ovr}, 1);
        check("R4 data kept", {24'b0, rx_data}, 32'h3C);
        check("R4 full kept", {31'b0, rx_full}, 1);
        host_read();
        send_word(8'h77); hclk(8);
        check("R4 dropped while ovr", {31'b0, rx_full}, 0);
        check("R4 data kept 2", {24'b0, rx_data}, 32'h3C);
        @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        check("R4 ovr cleared", {31'b0, ovr}, 0);
        send_word(8'hE1); hclk(8);
        check("R4 accept after clear", {24'b0, rx_data}, 32'hE1);
        host_read();

        // R8 wake formula in four flag states
        send_word(8'h11); hclk(8);
        sweep_wake(1'b1, 1'b1);
        host_read();
        sweep_wake(1'b0, 1'b1);
        host_write(8'h5A);
        sweep_wake(1'b0, 1'b0);
        send_word(8'h22); hclk(8);
        sweep_wake(1'b1, 1'b0);
        host_read();
        @(negedge clk); dir_tx = 1'b1;
        cap_clear(); tx_run(12);
        check("R5 pending byte sent", {24'b0, cap[7:0]}, 32'h5A);
        hclk(6);

        // R5/R6 transmit sweep over every code
        for (int v = 0; v < 256; v++) begin
            cap_clear();
            host_write(v[7:0]);
            check("R6 write clears ready", {31'b0, tx_ready}, 0);
            tx_run(12);
            check("R5 bit count", capn, 8);
            check("R5 tx data", {24'b0, cap[7:0]}, v);
            check("R5 oe idle", {31'b0, oe}, 0);
            hclk(5);
            check("R6 ready after load", {31'b0, tx_ready}, 1);
        end

        // R6 write while not ready is ignored
        cap_clear();
        host_write(8'hC7);
        host_write(8'h18);
        tx_run(12);
        check("R6 ignored write", {24'b0, cap[7:0]}, 32'hC7);
        hclk(5);
        tx_run(12);
        check("R6 nothing extra", capn, 8);
        hclk(5);

        // R7 back-to-back words
        cap_clear();
        host_write(8'h4B);
        tx_run(4);
        hclk(6);
        check("R7 ready mid word", {31'b0, tx_ready}, 1);
        host_write(8'hD2);
        tx_run(20);
        check("R7 two words", {16'b0, cap[15:0]}, 32'hD24B);
        check("R7 bit count", capn, 16);
        check("R7 no gap", gaps, 0);
        hclk(5);

        // R10 clocks in transmit mode with nothing to send
        send_word(8'hFF);
        check("R10 oe stays low", {31'b0, oe}, 0);
        hclk(8);
        check("R10 no rx word", {31'b0, rx_full}, 0);

        // R9 receive with the host clock stopped
        @(negedge clk); dir_tx = 1'b0; pie = 1'b1; rie = 1'b1; tie = 1'b0;
        @(negedge clk); clk_en = 1'b0;
        #20;
        check("R9 no wake before rx", {31'b0, wake}, 0);
        send_word(8'h6D);
        #1;
        check("R9 rx wake asleep", {31'b0, wake}, 1);
        check("R9 rx flag frozen", {31'b0, rx_full}, 0);
        clk_en = 1'b1;
        hclk(8);
        check("R9 rx flag after wake", {31'b0, rx_full}, 1);
        check("R9 rx data after wake", {24'b0, rx_data}, 32'h6D);
        host_read();

        // R9 transmit with the host clock stopped
        @(negedge clk); dir_tx = 1'b1; rie = 1'b0; tie = 1'b1;
        host_write(8'h96);
        hclk(4);
        @(negedge clk); clk_en = 1'b0;
        #20;
        check("R9 no wake before load", {31'b0, wake}, 0);
        cap_clear();
        tx_run(12);
        check("R9 tx wake asleep", {31'b0, wake}, 1);
        check("R9 tx flag frozen", {31'b0, tx_ready}, 0);
        check("R9 tx data asleep", {24'b0, cap[7:0]}, 32'h96);
        clk_en = 1'b1;
        hclk(6);
        check("R9 tx ready after wake", {31'b0, tx_ready}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule